// File: doc/BRIEF.md
# Key-Gated Flash Interface Configuration Bank

This block holds the settings a NAND flash controller needs before it can talk to a device: an interface configuration word (write-protect, page mode, address length, bus width) and a bus timing word split into seven delay fields. Both words sit behind a write lock. Software opens the lock by writing a 16-bit key to a dedicated lock register. The opening is good for exactly one write to one protected register. After that write the lock closes again by itself.

The bank sits on a simple synchronous register bus with an address, write data, a write strobe, a byte/halfword/word size code, a read strobe and registered read data. It also decodes a soft reset command written to the command register and holds a chip-enable mode bit. Every configuration and timing field is driven out as its own port, ready for the pin sequencer that uses them.

Top module: `flashcfg_lockbank`

## Requirements
- R1: After reset every output field is zero, every register reads back zero and the lock is closed.
- R2: A halfword (size 1) or word (size 2 or 3) write of 0xA25E in bits [15:0] to the lock register at offset 0x0C opens the lock. A byte write (size 0) to that register never opens it.
- R3: With the lock open, one write to the configuration word (offset 0x04) or the timing word (offset 0x08) takes effect. The lock then closes, so a further protected write is ignored until a new key arrives.
- R4: A write to a protected register while the lock is closed is ignored, and the register keeps its old value.
- R5: These accesses made between the key and the protected write close the lock: a write of any other value to the lock register, or any read or write of an address that is not a protected register.
- R6: Configuration word bit positions: bit 3 is write-protect enable, bit 2 is large-page mode, bit 1 is long (5-byte) addressing and bit 0 is 16-bit bus width. Each bit drives its own output.
- R7: Timing word bit positions: [25:24] is chip-enable-to-access delay, [23:19] is busy delay, [18:16] is bus turnaround, [15:12] is read-high, [11:8] is read-low, [7:4] is write-high and [3:0] is write-low. Each field drives its own output.
- R8: The write size selects which lanes are updated. A byte write (size 0) changes bits [7:0] only, a halfword write (size 1) changes bits [15:0] only, and sizes 2 and 3 change the whole word.
- R9: Writing 0xFF in bits [7:0] to the command register (offset 0x00) returns the configuration word, the timing word, the chip-enable bit and the lock to their reset state, and raises the soft reset output for one cycle. Other command values leave the registers unchanged.
- R10: The chip-enable register at offset 0x10 holds bit 0 (1 means the controller drives chip-enable normally). It is written without a key and drives its own output.
- R11: Read data appears on the cycle after the read strobe. Bits above a register's fields read as zero, and the command register, the lock register and unmapped offsets read as zero.
- R12: The protected registers read back their current value whether the lock is open or closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cfg_wp_en | output | 1 | Write-protect enable |
| cfg_large_page | output | 1 | Large-page mode |
| cfg_long_addr | output | 1 | 5-byte addressing |
| cfg_wide_bus | output | 1 | 16-bit bus width |
| tm_cea | output | 2 | Chip-enable-to-access delay |
| tm_busy | output | 5 | Busy delay |
| tm_turn | output | 3 | Bus turnaround |
| tm_rd_hi | output | 4 | Read strobe high time |
| tm_rd_lo | output | 4 | Read strobe low time |
| tm_wr_hi | output | 4 | Write strobe high time |
| tm_wr_lo | output | 4 | Write strobe low time |
| ce_normal | output | 1 | Controller drives chip-enable |
| ctl_soft_reset | output | 1 | One-cycle soft reset pulse |

## Verification
The bench uses the default parameters: an 8-bit address, the register offsets listed above and the 0xA25E key. With an 8-bit address, an unmapped offset near the top of the space (0xFC) can be reached, so the zero read-back and the lock-closing effect of a stray access are both tested. Because the timing word fills 26 of the 32 data bits, an all-ones write shows the top six bits reading as zero, and partial writes show that only the selected lanes change. Key sequences are driven with every size code, with a wrong value and with an intervening read, so that the byte-key rejection and the automatic closing of the lock are both observed at the read port.

// File: rtl/flashcfg_pkg.sv
package flashcfg_pkg;

    localparam int DATA_W = 32;

    typedef struct packed {
        logic wp_en;
        logic large_page;
        logic long_addr;
        logic wide_bus;
    } cfg_t;

    typedef struct packed {
        logic [1:0] cea;
        logic [4:0] busy;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } tim_t;

    typedef struct packed {
        cfg_t cfg;
        tim_t tim;
        logic ceh;
    } bank_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam int TIM_W = $bits(tim_t);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Lane merge according to access size.
    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [1:0]        sz
    );
        logic [DATA_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {old_v[DATA_W-1:8],  new_v[7:0]};
            SZ_HALF: r = {old_v[DATA_W-1:16], new_v[15:0]};
            default: r = new_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flashcfg_keygate.sv
module flashcfg_keygate
    import flashcfg_pkg::*;
#(
    parameter int              KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY  = 16'hA25E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [1:0]       key_size,
    input  logic [KEY_W-1:0] key_val,
    input  logic             prot_wr,
    input  logic             other_acc,
    input  logic             soft_rst,
    output logic             grant,
    output logic             is_open
);

    typedef struct packed {
        logic open;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        grant  = prot_wr && gate_q.open;
        if (soft_rst) begin
            gate_d.open = 1'b0;
        end else if (key_wr) begin
            gate_d.open = (key_size != SZ_BYTE) && (key_val == KEY);
        end else if (prot_wr || other_acc) begin
            gate_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign is_open = gate_q.open;

    assert_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> !is_open);

    assert_byte_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_size == SZ_BYTE) |=> !is_open);

    assert_stray_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (other_acc && !key_wr) |=> !is_open);

endmodule

// File: rtl/flashcfg_regfile.sv
module flashcfg_regfile
    import flashcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_tim,
    input  logic              wr_ceh,
    input  logic              grant,
    input  logic              soft_rst,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output bank_t             bank
);

    localparam int CFG_PAD = DATA_W - CFG_W;
    localparam int TIM_PAD = DATA_W - TIM_W;

    bank_t             bank_d, bank_q;
    logic [DATA_W-1:0] cfg_m, tim_m, ceh_m;

    always_comb begin
        bank_d = bank_q;
        cfg_m  = merge_lanes({{CFG_PAD{1'b0}}, bank_q.cfg}, wdata, size);
        tim_m  = merge_lanes({{TIM_PAD{1'b0}}, bank_q.tim}, wdata, size);
        ceh_m  = merge_lanes({{(DATA_W-1){1'b0}}, bank_q.ceh}, wdata, size);
        if (soft_rst) begin
            bank_d = '0;
        end else begin
            if (wr_cfg && grant) bank_d.cfg = cfg_t'(cfg_m[CFG_W-1:0]);
            if (wr_tim && grant) bank_d.tim = tim_t'(tim_m[TIM_W-1:0]);
            if (wr_ceh)          bank_d.ceh = ceh_m[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;

    assert_locked_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !grant && !soft_rst) |=> $stable(bank_q.cfg));

    assert_locked_tim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tim && !grant && !soft_rst) |=> $stable(bank_q.tim));

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_q == '0));

endmodule

// File: rtl/flashcfg_lockbank.sv
module flashcfg_lockbank
    import flashcfg_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_CMD  = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_CFG  = 8'h04,
    parameter logic [ADDR_W-1:0] OFS_TIM  = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_LOCK = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_CEH  = 8'h10,
    parameter logic [15:0]       UNLOCK_KEY = 16'hA25E,
    parameter logic [7:0]        RST_CODE   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              cfg_wp_en,
    output logic              cfg_large_page,
    output logic              cfg_long_addr,
    output logic              cfg_wide_bus,
    output logic [1:0]        tm_cea,
    output logic [4:0]        tm_busy,
    output logic [2:0]        tm_turn,
    output logic [3:0]        tm_rd_hi,
    output logic [3:0]        tm_rd_lo,
    output logic [3:0]        tm_wr_hi,
    output logic [3:0]        tm_wr_lo,
    output logic              ce_normal,
    output logic              ctl_soft_reset
);

    localparam int KEY_W = $bits(UNLOCK_KEY);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              srst;
    } port_t;

    port_t port_d, port_q;

    logic  hit_cmd, hit_cfg, hit_tim, hit_lock, hit_ceh, hit_prot;
    logic  key_wr, prot_wr, other_acc, soft_rst, grant, gate_open;
    bank_t bank;

    always_comb begin
        hit_cmd   = (bus_addr == OFS_CMD);
        hit_cfg   = (bus_addr == OFS_CFG);
        hit_tim   = (bus_addr == OFS_TIM);
        hit_lock  = (bus_addr == OFS_LOCK);
        hit_ceh   = (bus_addr == OFS_CEH);
        hit_prot  = hit_cfg || hit_tim;
        key_wr    = bus_wr && hit_lock;
        prot_wr   = bus_wr && hit_prot;
        other_acc = (bus_wr && !hit_prot && !hit_lock) || (bus_rd && !hit_prot);
        soft_rst  = bus_wr && hit_cmd && (bus_wdata[7:0] == RST_CODE);
    end

    flashcfg_keygate #(
        .KEY_W (KEY_W),
        .KEY   (UNLOCK_KEY)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_size  (bus_size),
        .key_val   (bus_wdata[KEY_W-1:0]),
        .prot_wr   (prot_wr),
        .other_acc (other_acc),
        .soft_rst  (soft_rst),
        .grant     (grant),
        .is_open   (gate_open)
    );

    flashcfg_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (bus_wr && hit_cfg),
        .wr_tim   (bus_wr && hit_tim),
        .wr_ceh   (bus_wr && hit_ceh),
        .grant    (grant),
        .soft_rst (soft_rst),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .bank     (bank)
    );

    always_comb begin
        port_d      = port_q;
        port_d.srst = soft_rst;
        if (bus_rd) begin
            port_d.rdata = '0;
            if (hit_cfg) port_d.rdata[CFG_W-1:0] = bank.cfg;
            if (hit_tim) port_d.rdata[TIM_W-1:0] = bank.tim;
            if (hit_ceh) port_d.rdata[0]         = bank.ceh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign bus_rdata      = port_q.rdata;
    assign ctl_soft_reset = port_q.srst;
    assign cfg_wp_en      = bank.cfg.wp_en;
    assign cfg_large_page = bank.cfg.large_page;
    assign cfg_long_addr  = bank.cfg.long_addr;
    assign cfg_wide_bus   = bank.cfg.wide_bus;
    assign tm_cea         = bank.tim.cea;
    assign tm_busy        = bank.tim.busy;
    assign tm_turn        = bank.tim.turn;
    assign tm_rd_hi       = bank.tim.rd_hi;
    assign tm_rd_lo       = bank.tim.rd_lo;
    assign tm_wr_hi       = bank.tim.wr_hi;
    assign tm_wr_lo       = bank.tim.wr_lo;
    assign ce_normal      = bank.ceh;

    assert_soft_reset_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctl_soft_reset && !ce_normal && !gate_open));

endmodule

// File: tb/flashcfg_lockbank_test.sv
`timescale 1ns/1ps
module flashcfg_lockbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cfg_wp_en, cfg_large_page, cfg_long_addr, cfg_wide_bus;
    logic [1:0]  tm_cea;
    logic [4:0]  tm_busy;
    logic [2:0]  tm_turn;
    logic [3:0]  tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo;
    logic        ce_normal, ctl_soft_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flashcfg_lockbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_wp_en(cfg_wp_en), .cfg_large_page(cfg_large_page),
        .cfg_long_addr(cfg_long_addr), .cfg_wide_bus(cfg_wide_bus),
        .tm_cea(tm_cea), .tm_busy(tm_busy), .tm_turn(tm_turn),
        .tm_rd_hi(tm_rd_hi), .tm_rd_lo(tm_rd_lo), .tm_wr_hi(tm_wr_hi), .tm_wr_lo(tm_wr_lo),
        .ce_normal(ce_normal), .ctl_soft_reset(ctl_soft_reset)
    );

    localparam logic [7:0] A_CMD = 8'h00, A_CFG = 8'h04, A_TIM = 8'h08,
                           A_LCK = 8'h0C, A_CEH = 8'h10, A_NONE = 8'hFC;

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_LCK,  2'd1, 32'h0000A25E, 4'd2},
        '{1'b0, A_CFG,  2'd2, 32'h00000006, 4'd2},
        '{1'b1, A_CFG,  2'd2, 32'h00000006, 4'd2},   // R2 key then write
        '{1'b0, A_CFG,  2'd2, 32'h00000009, 4'd3},
        '{1'b1, A_CFG,  2'd2, 32'h00000006, 4'd3},   // R3 second write ignored
        '{1'b0, A_LCK,  2'd2, 32'h0000A25E, 4'd2},
        '{1'b0, A_TIM,  2'd2, 32'hFFFFFFFF, 4'd11},
        '{1'b1, A_TIM,  2'd2, 32'h03FFFFFF, 4'd11},  // R11 top bits zero
        '{1'b0, A_LCK,  2'd0, 32'h0000A25E, 4'd2},
        '{1'b0, A_TIM,  2'd2, 32'h00000000, 4'd2},
        '{1'b1, A_TIM,  2'd2, 32'h03FFFFFF, 4'd2},   // R2 byte key rejected
        '{1'b0, A_LCK,  2'd1, 32'h00001234, 4'd5},
        '{1'b0, A_CFG,  2'd2, 32'h0000000F, 4'd5},
        '{1'b1, A_CFG,  2'd2, 32'h00000006, 4'd5},   // R5 wrong key
        '{1'b0, A_LCK,  2'd1, 32'h0000A25E, 4'd5},
        '{1'b1, A_CEH,  2'd2, 32'h00000000, 4'd5},
        '{1'b0, A_CFG,  2'd2, 32'h0000000F, 4'd5},
        '{1'b1, A_CFG,  2'd2, 32'h00000006, 4'd5},   // R5 stray read closes
        '{1'b0, A_LCK,  2'd1, 32'h0000A25E, 4'd8},
        '{1'b0, A_CFG,  2'd0, 32'hFFFFFFF9, 4'd8},
        '{1'b1, A_CFG,  2'd2, 32'h00000009, 4'd8},   // R8 byte write
        '{1'b0, A_LCK,  2'd1, 32'h0000A25E, 4'd8},
        '{1'b0, A_TIM,  2'd1, 32'h55551234, 4'd8},
        '{1'b1, A_TIM,  2'd2, 32'h03FF1234, 4'd8},   // R8 halfword write
        '{1'b0, A_LCK,  2'd3, 32'hFFFFA25E, 4'd8},
        '{1'b0, A_TIM,  2'd0, 32'h777777AB, 4'd8},
        '{1'b1, A_TIM,  2'd2, 32'h03FF12AB, 4'd12},  // R12 readable while closed
        '{1'b0, A_CEH,  2'd2, 32'h00000001, 4'd10},
        '{1'b1, A_CEH,  2'd2, 32'h00000001, 4'd10},  // R10 no key needed
        '{1'b1, A_NONE, 2'd2, 32'h00000000, 4'd11},  // R11 unmapped reads zero
        '{1'b0, A_CMD,  2'd2, 32'h00000000, 4'd9},
        '{1'b1, A_CFG,  2'd2, 32'h00000009, 4'd9}    // R9 non-reset command
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = 2'd2; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cfg outputs", {28'b0, cfg_wp_en, cfg_large_page, cfg_long_addr, cfg_wide_bus}, 32'h0);
        check("R1 timing outputs", {6'b0, tm_cea, tm_busy, tm_turn, tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo}, 32'h0);
        check("R1 ce/soft reset", {30'b0, ce_normal, ctl_soft_reset}, 32'h0);
        rst_n = 1'b1;
        bus_read(A_CFG, rv);
        check("R1 cfg readback", rv, 32'h0);
        bus_write(A_CFG, 2'd2, 32'hF);
        bus_read(A_CFG, rv);
        check("R1 lock closed after reset (R4)", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rv);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].data);
            end else begin
                bus_write(VECS[i].addr, VECS[i].size, VECS[i].data);
            end
        end

        // R6 configuration outputs (cfg = 9)
        check("R6 cfg fields", {28'b0, cfg_wp_en, cfg_large_page, cfg_long_addr, cfg_wide_bus}, 32'h9);
        // R7 timing outputs (timing word 03FF12AB)
        check("R7 cea", {30'b0, tm_cea}, 32'd3);
        check("R7 busy", {27'b0, tm_busy}, 32'd31);
        check("R7 turn", {29'b0, tm_turn}, 32'd7);
        check("R7 read/write times", {16'b0, tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo}, 32'h12AB);
        check("R10 ce_normal", {31'b0, ce_normal}, 32'd1);

        // R9 soft reset command
        bus_write(A_LCK, 2'd1, 32'hA25E);
        bus_write(A_CMD, 2'd0, 32'h000000FF);
        check("R9 soft reset pulse", {31'b0, ctl_soft_reset}, 32'd1);
        check("R9 cfg cleared", {28'b0, cfg_wp_en, cfg_large_page, cfg_long_addr, cfg_wide_bus}, 32'h0);
        check("R9 ce cleared", {31'b0, ce_normal}, 32'd0);
        @(negedge clk);
        check("R9 pulse one cycle", {31'b0, ctl_soft_reset}, 32'd0);
        bus_read(A_TIM, rv);
        check("R9 timing cleared", rv, 32'h0);
        bus_write(A_CFG, 2'd2, 32'hF);
        bus_read(A_CFG, rv);
        check("R9 lock closed by soft reset", rv, 32'h0);

        // R3 timing register also re-arms
        bus_write(A_LCK, 2'd2, 32'h0000A25E);
        bus_write(A_TIM, 2'd2, 32'h00000021);
        bus_write(A_TIM, 2'd2, 32'h00000033);
        bus_read(A_TIM, rv);
        check("R3 timing one write only", rv, 32'h21);

        // R5 stray write to unmapped address closes lock
        bus_write(A_LCK, 2'd1, 32'hA25E);
        bus_write(A_NONE, 2'd2, 32'h1);
        bus_write(A_CFG, 2'd2, 32'h5);
        bus_read(A_CFG, rv);
        check("R5 stray write closes", rv, 32'h0);

        // R1 hardware reset mid-run
        bus_write(A_CEH, 2'd2, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears ce", {31'b0, ce_normal}, 32'd0);
        check("R1 reset clears timing", {6'b0, tm_cea, tm_busy, tm_turn, tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule